// File: doc/BRIEF.md
# Serial Bit Stream Byte Packer with Two-Bank Swap

This block collects a slow, irregular serial bit stream from a compression engine and assembles it into bytes, which it writes into one half of a two-bank byte memory. Each bit arrives as a data level plus a strobe. A separate pulse marks the end of a group of frames. All three inputs are asynchronous to the fast system clock. They pass through a two-flop synchronizer and then an edge-sensitive capture machine. The first bit of every byte lands in the most significant position.

When a group ends, any unfinished byte is written out and the packer raises its finish flag. A small arbiter also watches a finish flag from the downstream reader. Once both flags are high, in either order, it flips which bank is written and which is read. It then raises an acknowledge that both sides share. The packer starts the new bank at address zero. Bits that arrive while the packer is waiting for the acknowledge are dropped.

Top module: `sbp_top`

## Requirements
- R1: Bits are packed most significant first: the first bit captured after a byte starts goes to bit 7 of `mem_wdata`, and each later bit goes one position lower.
- R2: One strobe high pulse yields exactly one captured bit, however long the strobe stays high. The next bit needs the strobe to go low and then high again.
- R3: When the eighth bit is captured, `mem_we` is high for exactly one cycle with the completed byte. The next byte is written at the next address (+1) and starts from an all-zero byte.
- R4: A rising `grp_end` writes a partially filled byte. The captured bits sit at the top and the unused low bits are 0. If no bits are pending, no write takes place.
- R5: After the group-end flush, `pk_done` rises and stays high until `swap_ok` rises.
- R6: Strobes that arrive while `pk_done` is high cause no write and leave no bits in the next byte.
- R7: `swap_ok` rises and `mem_bank` toggles once, only after both `pk_done` and `rd_done` are high, whichever of the two rose first.
- R8: `swap_ok` stays high until both `pk_done` and `rd_done` are low. It falls in the cycle after that.
- R9: The first byte written after a swap goes to address 0 of the new bank.
- R10: After reset, `mem_we`, `pk_done`, `swap_ok` and `mem_bank` are 0. A byte-completing strobe edge, or a `grp_end` edge, shows its result (`mem_we` or `pk_done`) on the fourth clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Serial data bit, stable while the strobe is high |
| bit_stb | input | 1 | Asynchronous data strobe |
| grp_end | input | 1 | Asynchronous end-of-group marker |
| rd_done | input | 1 | Downstream reader finished with its bank |
| mem_we | output | 1 | Byte write enable, one cycle per byte |
| mem_bank | output | 1 | Bank currently being written; the reader uses the other |
| mem_addr | output | ADDR_W | Byte address within the write bank |
| mem_wdata | output | BYTE_W | Packed byte |
| pk_done | output | 1 | Packer finish flag |
| swap_ok | output | 1 | Swap acknowledge to packer and reader |

## Verification
Each input change goes through two synchronizer edges before the packer acts on it. A write pulse or finish flag is therefore due on the fourth edge after a strobe or group-end edge. The bench drives inputs on falling edges and counts falling edges until the output appears, and it expects exactly four. The acknowledge and bank flip are due one edge after the second finish flag is seen. The packer's flag falls one edge after that, and the acknowledge falls one edge after both flags are low. The bench samples each of these at the expected falling edge. Written bytes are logged on falling edges, so each write pulse is recorded exactly once.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  typedef enum logic [2:0] {
    PK_WAIT_HI = 3'd0,
    PK_CHECK   = 3'd1,
    PK_WAIT_LO = 3'd2,
    PK_FLUSH   = 3'd3,
    PK_DONE    = 3'd4
  } pk_state_t;

  typedef enum logic {
    SW_WAIT_DONE = 1'b0,
    SW_ACK       = 1'b1
  } sw_state_t;

endpackage

// File: rtl/sbp_sync.sv
module sbp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sbp_packer.sv
module sbp_packer
  import sbp_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_s,
  input  logic              stb_s,
  input  logic              grp_s,
  input  logic              swap_ok,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              pk_done
);

  localparam logic [BYTE_W-1:0] PTR_INIT = BYTE_W'(1) << (BYTE_W - 1);

  pk_state_t         state_q, state_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [BYTE_W-1:0] ptr_q, ptr_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              we_q, we_n;
  logic [BYTE_W-1:0] wd_q, wd_n;
  logic [ADDR_W-1:0] wa_q, wa_n;
  logic              grp_q;
  logic              pend_q, pend_n;
  logic              ok_q;
  logic              grp_rise, ok_rise;

  assign grp_rise = grp_s & ~grp_q;
  assign ok_rise  = swap_ok & ~ok_q;

  always_comb begin
    state_n = state_q;
    sh_n    = sh_q;
    ptr_n   = ptr_q;
    addr_n  = addr_q;
    we_n    = 1'b0;
    wd_n    = wd_q;
    wa_n    = wa_q;
    pend_n  = pend_q;
    unique case (state_q)
      PK_WAIT_HI: begin
        if (stb_s) begin
          sh_n    = sh_q | (bit_s ? ptr_q : '0);
          ptr_n   = ptr_q >> 1;
          state_n = PK_CHECK;
          if (grp_rise) pend_n = 1'b1;
        end else if (grp_rise || pend_q) begin
          pend_n  = 1'b0;
          state_n = PK_FLUSH;
        end
      end
      PK_CHECK: begin
        if (grp_rise) pend_n = 1'b1;
        if (ptr_q == '0) begin
          we_n   = 1'b1;
          wd_n   = sh_q;
          wa_n   = addr_q;
          addr_n = addr_q + 1'b1;
          sh_n   = '0;
          ptr_n  = PTR_INIT;
        end
        state_n = PK_WAIT_LO;
      end
      PK_WAIT_LO: begin
        if (grp_rise) pend_n = 1'b1;
        if (!stb_s) state_n = PK_WAIT_HI;
      end
      PK_FLUSH: begin
        if (ptr_q != PTR_INIT) begin
          we_n   = 1'b1;
          wd_n   = sh_q;
          wa_n   = addr_q;
          addr_n = addr_q + 1'b1;
        end
        sh_n    = '0;
        ptr_n   = PTR_INIT;
        pend_n  = 1'b0;
        state_n = PK_DONE;
      end
      PK_DONE: begin
        pend_n = 1'b0;
        if (ok_rise) begin
          addr_n  = '0;
          state_n = PK_WAIT_LO;
        end
      end
      default: state_n = PK_WAIT_HI;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PK_WAIT_HI;
      sh_q    <= '0;
      ptr_q   <= PTR_INIT;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wd_q    <= '0;
      wa_q    <= '0;
      grp_q   <= 1'b0;
      pend_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      sh_q    <= sh_n;
      ptr_q   <= ptr_n;
      addr_q  <= addr_n;
      we_q    <= we_n;
      if (we_n) begin
        wd_q <= wd_n;
        wa_q <= wa_n;
      end
      grp_q   <= grp_s;
      pend_q  <= pend_n;
      ok_q    <= swap_ok;
    end
  end

  assign mem_we    = we_q;
  assign mem_wdata = wd_q;
  assign mem_addr  = wa_q;
  assign pk_done   = (state_q == PK_DONE);

  // R3
  single_write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R5
  done_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pk_done && !swap_ok |=> pk_done);

  // R9
  addr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pk_done) |-> addr_q == '0);

endmodule

// File: rtl/sbp_swap_arb.sv
module sbp_swap_arb
  import sbp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pk_done,
  input  logic rd_done,
  output logic swap_ok,
  output logic bank_sel
);

  sw_state_t state_q, state_n;
  logic      bank_q, bank_n;

  always_comb begin
    state_n = state_q;
    bank_n  = bank_q;
    unique case (state_q)
      SW_WAIT_DONE: begin
        if (pk_done && rd_done) begin
          bank_n  = ~bank_q;
          state_n = SW_ACK;
        end
      end
      SW_ACK: begin
        if (!pk_done && !rd_done) state_n = SW_WAIT_DONE;
      end
      default: state_n = SW_WAIT_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_WAIT_DONE;
      bank_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      bank_q  <= bank_n;
    end
  end

  assign swap_ok  = (state_q == SW_ACK);
  assign bank_sel = bank_q;

  // R7
  swap_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swap_ok) |-> $past(pk_done && rd_done));

  // R7
  bank_flip_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_sel) |-> $rose(swap_ok));

  // R8
  ack_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_ok && (pk_done || rd_done) |=> swap_ok);

endmodule

// File: rtl/sbp_top.sv
module sbp_top #(
  parameter int ADDR_W      = 14,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_stb,
  input  logic              grp_end,
  input  logic              rd_done,
  output logic              mem_we,
  output logic              mem_bank,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              pk_done,
  output logic              swap_ok
);

  logic [2:0] raw_in, sync_out;
  logic       done_w, ok_w;

  assign raw_in = {grp_end, bit_stb, bit_in};

  sbp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_out)
  );

  sbp_packer #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_s     (sync_out[0]),
    .stb_s     (sync_out[1]),
    .grp_s     (sync_out[2]),
    .swap_ok   (ok_w),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pk_done   (done_w)
  );

  sbp_swap_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pk_done  (done_w),
    .rd_done  (rd_done),
    .swap_ok  (ok_w),
    .bank_sel (mem_bank)
  );

  assign pk_done = done_w;
  assign swap_ok = ok_w;

endmodule

// File: tb/sbp_top_bench.sv
module sbp_top_bench;

  localparam int ADDR_W = 14;
  localparam int BYTE_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bit_in = 1'b0, bit_stb = 1'b0, grp_end = 1'b0, rd_done = 1'b0;
  logic              mem_we, mem_bank, pk_done, swap_ok;
  logic [ADDR_W-1:0] mem_addr;
  logic [BYTE_W-1:0] mem_wdata;

  int checks = 0;
  int errors = 0;
  int wr_n = 0;
  logic              log_bank [0:31];
  logic [ADDR_W-1:0] log_addr [0:31];
  logic [BYTE_W-1:0] log_data [0:31];

  always #2.5 clk = ~clk;

  sbp_top #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_sbp_top (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_stb(bit_stb),
    .grp_end(grp_end), .rd_done(rd_done), .mem_we(mem_we), .mem_bank(mem_bank),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pk_done(pk_done), .swap_ok(swap_ok)
  );

  always @(negedge clk) begin
    if (mem_we && wr_n < 32) begin
      log_bank[wr_n] = mem_bank;
      log_addr[wr_n] = mem_addr;
      log_data[wr_n] = mem_wdata;
      wr_n = wr_n + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int hi_cycles);
    @(negedge clk);
    bit_in = b;
    bit_stb = 1'b1;
    repeat (hi_cycles) @(negedge clk);
    bit_stb = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i], 18);
  endtask

  task automatic expect_write(input string req, input int idx, input int bank,
                              input int addr, input int data);
    check({req, " write count"}, wr_n > idx, 1);
    if (wr_n > idx) begin
      check({req, " bank"}, log_bank[idx], bank);
      check({req, " addr"}, log_addr[idx], addr);
      check({req, " data"}, log_data[idx], data);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset we", mem_we, 0);
    check("R10 reset done", pk_done, 0);
    check("R10 reset ok", swap_ok, 0);
    check("R10 reset bank", mem_bank, 0);
  endtask

  // R1 R3: MSB-first packing, one pulse per byte, address step
  task automatic t_msb_bytes();
    send_byte(8'hB2);
    expect_write("R1", 0, 0, 0, 8'hB2);
    // R2: one very long strobe counts as a single bit
    send_bit(1'b1, 60);
    check("R2 no early write", wr_n, 1);
    for (int i = 0; i < 7; i++) send_bit(1'b0, 18);
    expect_write("R2", 1, 0, 1, 8'h80);
    check("R3 single pulse per byte", wr_n, 2);
  endtask

  // R10: byte-completing strobe edge to write pulse
  task automatic t_latency();
    int k;
    for (int i = 0; i < 7; i++) send_bit(1'b1, 18);
    @(negedge clk);
    bit_in = 1'b1;
    bit_stb = 1'b1;
    k = 0;
    while (!mem_we && k < 20) begin
      @(negedge clk);
      k++;
    end
    check("R10 strobe to write cycles", k, 4);
    repeat (14) @(negedge clk);
    bit_stb = 1'b0;
    repeat (10) @(negedge clk);
    expect_write("R3", 2, 0, 2, 8'hFF);
  endtask

  // R4 R5 R10: partial byte flush and finish flag
  task automatic t_flush();
    int k;
    send_bit(1'b1, 18);
    send_bit(1'b1, 18);
    send_bit(1'b0, 18);
    @(negedge clk);
    grp_end = 1'b1;
    k = 0;
    while (!pk_done && k < 20) begin
      @(negedge clk);
      k++;
    end
    check("R10 group end to done cycles", k, 4);
    check("R4 flush pulse with done", mem_we, 1);
    repeat (6) @(negedge clk);
    grp_end = 1'b0;
    expect_write("R4", 3, 0, 3, 8'hC0);
  endtask

  // R5 R6: strobes during the wait are dropped, flag held
  task automatic t_discard();
    for (int i = 0; i < 3; i++) send_bit(1'b1, 18);
    check("R6 no write while waiting", wr_n, 4);
    check("R5 done held", pk_done, 1);
    check("R7 no ack without reader", swap_ok, 0);
    check("R7 bank unchanged", mem_bank, 0);
  endtask

  // R7 R8: packer first, then reader
  task automatic t_swap_packer_first();
    @(negedge clk);
    rd_done = 1'b1;
    @(negedge clk);
    check("R7 ack after both", swap_ok, 1);
    check("R7 bank toggled", mem_bank, 1);
    @(negedge clk);
    check("R5 done drops after ack", pk_done, 0);
    check("R8 ack held while reader done", swap_ok, 1);
    repeat (3) @(negedge clk);
    check("R8 ack still held", swap_ok, 1);
    rd_done = 1'b0;
    @(negedge clk);
    check("R8 ack released", swap_ok, 0);
    check("R7 bank stays", mem_bank, 1);
  endtask

  // R9 R6: new bank starts at 0 and no discarded bits leak in
  task automatic t_after_swap();
    send_byte(8'h5A);
    expect_write("R9", 4, 1, 0, 8'h5A);
  endtask

  // R4 R7: empty flush, reader finished first
  task automatic t_swap_reader_first();
    int k;
    @(negedge clk);
    rd_done = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 no ack with reader only", swap_ok, 0);
    grp_end = 1'b1;
    k = 0;
    while (!pk_done && k < 20) begin
      @(negedge clk);
      k++;
    end
    check("R10 empty flush done cycles", k, 4);
    @(negedge clk);
    check("R7 ack reader first", swap_ok, 1);
    check("R7 bank back to 0", mem_bank, 0);
    grp_end = 1'b0;
    repeat (4) @(negedge clk);
    check("R4 empty flush writes nothing", wr_n, 5);
    rd_done = 1'b0;
    @(negedge clk);
    check("R8 ack released again", swap_ok, 0);
    send_byte(8'h3C);
    expect_write("R9", 5, 0, 0, 8'h3C);
  endtask

  initial begin
    t_reset();
    t_msb_bytes();
    t_latency();
    t_flush();
    t_discard();
    t_swap_packer_first();
    t_after_swap();
    t_swap_reader_first();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule